// File: doc/BRIEF.md
# Chip-Select Segment Window Map

This block keeps one window register per flash chip select. Each register describes an address window as a pair of 8 MiB unit numbers: the first unit inside the window and the first unit past its end. Software writes a register over a simple register port. The block cleans each write before it takes effect. The start of chip select 0 is pinned to the window base. When `LOCK_LAST_END` is set, the end of the last chip select is pinned to its reset value. A window that lies wholly outside the flash window is refused. A window that is misaligned or overlaps another window is still stored, but a flag is raised.

Write handling is a two-state machine. In `ST_IDLE` the block accepts a write. A write that changes nothing is dropped in `ST_IDLE`, and the machine stays there (IDLE→IDLE). An accepted write moves it to `ST_CHECK` (IDLE→CHECK). In `ST_CHECK` the cleaned window is validated and committed, and the machine always returns to `ST_IDLE` (CHECK→IDLE). `wr_ready` is high only in `ST_IDLE`.

Two combinational paths use the stored windows:
- **Decode path.** It maps a bus address to one chip select and gives the offset inside that window.
- **Access path.** It folds an offset that is too large for a chip select's window back into range, and reports that it did so.

Top module: `segwin_map`

## Requirements
- R1: After reset, every register reads `{end[7:0], start[7:0], 16'h0000}`, taken from the reset tables (defaults: CS0 40..48, CS1 48..4C, CS2 4C..50 hex units). `wr_ready` is 1 and all three error flags are 0.
- R2: A write is ignored if its chip-select index is not below `NUM_CS`, or if its 32-bit data equals the register's current read value. `wr_ready` stays 1, and no register or flag changes.
- R3: An accepted write drops `wr_ready` for exactly one cycle (`ST_CHECK`). The result is visible at `rd_data` and on the flags from the following cycle onward.
- R4: A write to CS0 always stores the window base as its start. The end field from the write is kept.
- R5: With `LOCK_LAST_END=1`, a write to the last chip select always stores that chip select's reset end unit.
- R6: After the fixes of R4 and R5, a write is refused when end ≤ base, or when start > base + span (unsigned units). A refused write leaves the register unchanged and sets `err_reject`. It also clears the misalign and overlap flags.
- R7: A stored write whose size (end − start, 8 bits) is non-zero and for which `start & (size−1)` is non-zero sets `err_misalign`.
- R8: A stored write whose window [start, end) intersects the window of any other chip select sets `err_overlap`. The write is still stored.
- R9: `dec_hit` is one-hot or zero. Bit i is set for the lowest chip select with start ≤ `dec_addr[31:23]` < end. `dec_off` is `dec_addr` minus (start << 23), or 0 when nothing hits.
- R10: With size bytes S = (end − start) << 23 of chip select `acc_cs`:
  - if `acc_off` ≥ S, then `acc_wrap_err` = 1 and `acc_wrapped` = `acc_off & (S−1)`;
  - otherwise `acc_wrap_err` = 0 and `acc_wrapped` = `acc_off`.
- R11: Bits [15:0] of write data are discarded and always read back as zero. Each error flag holds its value until the next commit in `ST_CHECK`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_cs | input | CS_W | Chip select addressed by the write |
| wr_data | input | 32 | Write data: end unit in [31:24], start unit in [23:16] |
| wr_ready | output | 1 | High in ST_IDLE, when a write can be taken |
| rd_cs | input | CS_W | Chip select to read |
| rd_data | output | 32 | Register value of rd_cs (0 if out of range) |
| dec_addr | input | 32 | Bus address to decode |
| dec_hit | output | NUM_CS | One-hot chip-select hit, lowest index wins |
| dec_off | output | 32 | Offset of dec_addr inside the hit window |
| acc_cs | input | CS_W | Chip select for the offset fold |
| acc_off | input | 32 | Offset into acc_cs's window |
| acc_wrapped | output | 32 | Offset reduced into the window |
| acc_wrap_err | output | 1 | acc_off was not below the window size |
| err_reject | output | 1 | Last checked write was refused |
| err_misalign | output | 1 | Last stored write was misaligned |
| err_overlap | output | 1 | Last stored write overlapped another window |

## Verification
The assertions check the following on every cycle:
- `ST_CHECK` lasts a single cycle.
- Registers move only on leaving `ST_CHECK`.
- A write that matches the current value never leaves `ST_IDLE`.
- CS0 keeps the base start, and the last end stays locked.
- A refused commit leaves every register untouched.
- The decoder never reports two hits.
- An offset that is in range passes through unchanged.

Only the bench scenarios can show the following:
- the actual field values after a fix-up;
- the reject boundaries (start exactly at base + span is kept);
- the misalign and overlap verdicts against the other windows;
- the priority choice between overlapping windows;
- the folded offset values.

// File: rtl/segwin_pkg.sv
package segwin_pkg;
    localparam int UNIT_W     = 8;
    localparam int UNIT_SHIFT = 23;
    localparam int BUS_W      = 32;

    typedef logic [UNIT_W-1:0] unit_t;

    typedef struct packed {
        unit_t end_u;
        unit_t start_u;
    } seg_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_CHECK = 1'b1
    } wr_state_e;

    function automatic logic [BUS_W-1:0] seg_word(input seg_t s);
        return {s.end_u, s.start_u, {(BUS_W - 2*UNIT_W){1'b0}}};
    endfunction

    function automatic logic [BUS_W-1:0] unit_to_bytes(input unit_t u);
        return {{(BUS_W - UNIT_W - UNIT_SHIFT){1'b0}}, u, {UNIT_SHIFT{1'b0}}};
    endfunction
endpackage

// File: rtl/segwin_fix.sv
module segwin_fix
    import segwin_pkg::*;
#(
    parameter unit_t BASE_U        = 8'h40,
    parameter unit_t SPAN_U        = 8'h20,
    parameter bit    LOCK_LAST_END = 1'b1,
    parameter unit_t LAST_END      = 8'h50
) (
    input  seg_t raw,
    input  logic is_first,
    input  logic is_last,
    output seg_t fixed,
    output logic reject,
    output logic misalign
);
    localparam logic [UNIT_W:0] LIMIT_HI = {1'b0, BASE_U} + {1'b0, SPAN_U};

    unit_t size_u;

    always_comb begin
        fixed.start_u = is_first ? BASE_U : raw.start_u;
        fixed.end_u   = (LOCK_LAST_END && is_last) ? LAST_END : raw.end_u;
        reject = (fixed.end_u <= BASE_U) || ({1'b0, fixed.start_u} > LIMIT_HI);
        size_u = fixed.end_u - fixed.start_u;
        misalign = (size_u != '0) && ((fixed.start_u & (size_u - 8'd1)) != '0);
    end
endmodule

// File: rtl/segwin_overlap.sv
module segwin_overlap
    import segwin_pkg::*;
#(
    parameter int NUM_CS = 3,
    parameter int CS_W   = 2
) (
    input  seg_t [NUM_CS-1:0] segs,
    input  seg_t              cand,
    input  logic [CS_W-1:0]   cand_cs,
    output logic              overlap
);
    logic [NUM_CS-1:0] clash;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_clash
        assign clash[i] = (CS_W'(i) != cand_cs)
                       && (cand.end_u > segs[i].start_u)
                       && (cand.start_u < segs[i].end_u);
    end

    assign overlap = |clash;
endmodule

// File: rtl/segwin_decode.sv
module segwin_decode
    import segwin_pkg::*;
#(
    parameter int NUM_CS = 3,
    parameter int CS_W   = 2
) (
    input  seg_t [NUM_CS-1:0] segs,
    input  logic [BUS_W-1:0]  dec_addr,
    output logic [NUM_CS-1:0] dec_hit,
    output logic [BUS_W-1:0]  dec_off,
    input  logic [CS_W-1:0]   acc_cs,
    input  logic [BUS_W-1:0]  acc_off,
    output logic [BUS_W-1:0]  acc_wrapped,
    output logic              acc_wrap_err
);
    localparam logic [CS_W-1:0] LAST_CS = CS_W'(NUM_CS - 1);

    logic [NUM_CS-1:0] raw_hit;
    logic [UNIT_W:0]   addr_u;
    seg_t              acc_seg;
    logic [BUS_W-1:0]  size_b;

    assign addr_u = dec_addr[BUS_W-1:UNIT_SHIFT];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_hit
        assign raw_hit[i] = (addr_u >= {1'b0, segs[i].start_u})
                         && (addr_u <  {1'b0, segs[i].end_u});
    end

    // isolate lowest set bit: lowest chip select wins
    assign dec_hit = raw_hit & (~raw_hit + NUM_CS'(1));

    always_comb begin
        dec_off = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (dec_hit[i]) dec_off = dec_addr - unit_to_bytes(segs[i].start_u);
        end
    end

    assign acc_seg      = (acc_cs <= LAST_CS) ? segs[acc_cs] : '0;
    assign size_b       = unit_to_bytes(acc_seg.end_u - acc_seg.start_u);
    assign acc_wrap_err = (acc_off >= size_b);
    assign acc_wrapped  = acc_wrap_err ? (acc_off & (size_b - 32'd1)) : acc_off;
endmodule

// File: rtl/segwin_map.sv
module segwin_map
    import segwin_pkg::*;
#(
    parameter int                     NUM_CS        = 3,
    parameter int                     CS_W          = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    parameter unit_t                  BASE_U        = 8'h40,
    parameter unit_t                  SPAN_U        = 8'h20,
    parameter logic [NUM_CS*8-1:0]    RST_START     = {8'h4C, 8'h48, 8'h40},
    parameter logic [NUM_CS*8-1:0]    RST_END       = {8'h50, 8'h4C, 8'h48},
    parameter bit                     LOCK_LAST_END = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CS_W-1:0]   wr_cs,
    input  logic [31:0]       wr_data,
    output logic              wr_ready,
    input  logic [CS_W-1:0]   rd_cs,
    output logic [31:0]       rd_data,
    input  logic [31:0]       dec_addr,
    output logic [NUM_CS-1:0] dec_hit,
    output logic [31:0]       dec_off,
    input  logic [CS_W-1:0]   acc_cs,
    input  logic [31:0]       acc_off,
    output logic [31:0]       acc_wrapped,
    output logic              acc_wrap_err,
    output logic              err_reject,
    output logic              err_misalign,
    output logic              err_overlap
);
    localparam logic [CS_W-1:0] LAST_CS  = CS_W'(NUM_CS - 1);
    localparam unit_t           LAST_END = RST_END[(NUM_CS-1)*UNIT_W +: UNIT_W];

    seg_t [NUM_CS-1:0] segs;
    wr_state_e         state, state_nx;
    logic [CS_W-1:0]   pend_cs;
    seg_t              pend_raw;
    seg_t              fix_seg;
    logic              fix_reject, fix_misalign, fix_overlap;
    logic              wr_cs_ok, wr_take;
    logic [31:0]       cur_word;

    assign wr_cs_ok = (wr_cs <= LAST_CS);
    assign cur_word = wr_cs_ok ? seg_word(segs[wr_cs]) : 32'h0;
    assign wr_take  = wr_en && wr_cs_ok && (wr_data != cur_word);
    assign wr_ready = (state == ST_IDLE);
    assign rd_data  = (rd_cs <= LAST_CS) ? seg_word(segs[rd_cs]) : 32'h0;

    segwin_fix #(
        .BASE_U(BASE_U), .SPAN_U(SPAN_U),
        .LOCK_LAST_END(LOCK_LAST_END), .LAST_END(LAST_END)
    ) u_fix (
        .raw(pend_raw), .is_first(pend_cs == '0), .is_last(pend_cs == LAST_CS),
        .fixed(fix_seg), .reject(fix_reject), .misalign(fix_misalign)
    );

    segwin_overlap #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_ovl (
        .segs(segs), .cand(fix_seg), .cand_cs(pend_cs), .overlap(fix_overlap)
    );

    segwin_decode #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_dec (
        .segs(segs), .dec_addr(dec_addr), .dec_hit(dec_hit), .dec_off(dec_off),
        .acc_cs(acc_cs), .acc_off(acc_off),
        .acc_wrapped(acc_wrapped), .acc_wrap_err(acc_wrap_err)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE:  state_nx = wr_take ? ST_CHECK : ST_IDLE;
            ST_CHECK: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // registers and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CS; i++) begin
                segs[i].start_u <= RST_START[i*UNIT_W +: UNIT_W];
                segs[i].end_u   <= RST_END[i*UNIT_W +: UNIT_W];
            end
            pend_cs      <= '0;
            pend_raw     <= '0;
            err_reject   <= 1'b0;
            err_misalign <= 1'b0;
            err_overlap  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (wr_take) begin
                        pend_cs  <= wr_cs;
                        pend_raw <= wr_data[31:16];
                    end
                end
                ST_CHECK: begin
                    err_reject   <= fix_reject;
                    err_misalign <= !fix_reject && fix_misalign;
                    err_overlap  <= !fix_reject && fix_overlap;
                    if (!fix_reject) segs[pend_cs] <= fix_seg;
                end
                default: ;
            endcase
        end
    end

    // R3: the check state lasts exactly one cycle
    a_r3_check_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |=> wr_ready);

    // R3: registers only change when leaving the check state
    a_r3_hold_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |=> $stable(segs));

    // R2: an unchanged value never enters the check state
    a_r2_equal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && wr_en && wr_cs_ok && wr_data == rd_data && rd_cs == wr_cs)
        |=> wr_ready);

    // R4: chip select 0 keeps the base start
    a_r4_cs0_base: assert property (@(posedge clk) disable iff (!rst_n)
        segs[0].start_u == BASE_U);

    // R5: locked last end
    if (LOCK_LAST_END) begin : g_lock_chk
        a_r5_last_end: assert property (@(posedge clk) disable iff (!rst_n)
            segs[NUM_CS-1].end_u == LAST_END);
    end

    // R6: a refused commit leaves the registers untouched
    a_r6_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!wr_ready) && err_reject) |-> $stable(segs));

    // R9: at most one chip select hit
    a_r9_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_hit));

    // R10: in-range offset passes unchanged
    a_r10_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wrap_err |-> (acc_wrapped == acc_off));
endmodule

// File: tb/tb_segwin_map.sv
`timescale 1ns/1ps
module tb_segwin_map;
    localparam int NCS = 3;
    localparam logic [7:0] BASE = 8'h40;
    localparam logic [7:0] SPAN = 8'h20;
    localparam logic [7:0] LEND = 8'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_cs = '0;
    logic [31:0] wr_data = '0;
    logic wr_ready;
    logic [1:0] rd_cs = '0;
    logic [31:0] rd_data;
    logic [31:0] dec_addr = '0;
    logic [NCS-1:0] dec_hit;
    logic [31:0] dec_off;
    logic [1:0] acc_cs = '0;
    logic [31:0] acc_off = '0;
    logic [31:0] acc_wrapped;
    logic acc_wrap_err, err_reject, err_misalign, err_overlap;

    int tests = 0;
    int fails = 0;
    logic [7:0] ms [NCS];
    logic [7:0] me [NCS];
    logic m_rej = 1'b0, m_mis = 1'b0, m_ovl = 1'b0;

    always #10 clk = ~clk;

    segwin_map dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cs(wr_cs), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_cs(rd_cs), .rd_data(rd_data), .dec_addr(dec_addr),
        .dec_hit(dec_hit), .dec_off(dec_off), .acc_cs(acc_cs), .acc_off(acc_off),
        .acc_wrapped(acc_wrapped), .acc_wrap_err(acc_wrap_err),
        .err_reject(err_reject), .err_misalign(err_misalign), .err_overlap(err_overlap)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        for (int i = 0; i < NCS; i++) begin
            rd_cs = 2'(i);
            #1;
            chk(req, rd_data, {me[i], ms[i], 16'h0});
        end
        chk(req, {29'd0, err_reject, err_misalign, err_overlap}, {29'd0, m_rej, m_mis, m_ovl});
    endtask

    task automatic do_write(input int cs, input logic [31:0] d, input string req);
        logic acc;
        logic [7:0] s, e, sz;
        acc = (cs < NCS) && (d != {me[cs], ms[cs], 16'h0});
        @(negedge clk);
        wr_en = 1'b1; wr_cs = 2'(cs); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        chk({req, " R3 ready"}, {31'd0, wr_ready}, {31'd0, !acc});
        @(negedge clk);
        if (acc) begin
            s = (cs == 0) ? BASE : d[23:16];
            e = (cs == NCS - 1) ? LEND : d[31:24];
            m_rej = (e <= BASE) || ({1'b0, s} > ({1'b0, BASE} + {1'b0, SPAN}));
            sz = e - s;
            m_mis = !m_rej && (sz != 0) && ((s & (sz - 8'd1)) != 0);
            m_ovl = 1'b0;
            for (int i = 0; i < NCS; i++)
                if (i != cs && e > ms[i] && s < me[i]) m_ovl = 1'b1;
            m_ovl = m_ovl && !m_rej;
            if (!m_rej) begin ms[cs] = s; me[cs] = e; end
        end
        check_state(req);
    endtask

    task automatic chk_dec(input logic [31:0] a, input string req);
        logic [NCS-1:0] h;
        logic [31:0] o;
        logic [8:0] u;
        h = '0; o = '0; u = a[31:23];
        for (int i = NCS - 1; i >= 0; i--)
            if (u >= {1'b0, ms[i]} && u < {1'b0, me[i]}) begin
                h = NCS'(1) << i;
                o = a - {1'b0, ms[i], 23'd0};
            end
        dec_addr = a;
        #1;
        chk({req, " R9 hit"}, {29'd0, dec_hit}, {29'd0, h});
        chk({req, " R9 off"}, dec_off, o);
    endtask

    task automatic chk_acc(input int cs, input logic [31:0] off, input string req);
        logic [31:0] sb;
        logic err;
        sb = {1'b0, me[cs] - ms[cs], 23'd0};
        err = off >= sb;
        acc_cs = 2'(cs); acc_off = off;
        #1;
        chk({req, " R10 err"}, {31'd0, acc_wrap_err}, {31'd0, err});
        chk({req, " R10 val"}, acc_wrapped, err ? (off & (sb - 1)) : off);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        ms[0] = 8'h40; me[0] = 8'h48;
        ms[1] = 8'h48; me[1] = 8'h4C;
        ms[2] = 8'h4C; me[2] = 8'h50;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", {31'd0, wr_ready}, 32'd1);
        check_state("R1 reset");

        do_write(1, 32'h4C48_0000, "R2 same value");
        do_write(3, 32'h1234_0000, "R2 bad cs");
        do_write(0, 32'h5044_1234, "R4 R8 R11 cs0");
        do_write(2, 32'h5850_0000, "R5 last end");
        do_write(1, 32'h4030_0000, "R6 end at base");
        do_write(1, 32'h7061_0000, "R6 start past top");
        do_write(1, 32'h6460_0000, "R6 start at top kept");
        do_write(1, 32'h5652_0000, "R7 misalign");
        do_write(0, 32'h4840_0000, "restore0");
        do_write(2, 32'h504C_0000, "restore2");
        do_write(1, 32'h4C48_0000, "restore1");

        chk_dec(32'h2000_0000, "base");
        chk_dec(32'h247F_FFFF, "cs1 top");
        chk_dec(32'h2800_0000, "miss");
        do_write(1, 32'h5040_0000, "R8 overlap cs1");
        chk_dec(32'h2000_0010, "priority");
        chk_dec(32'h2400_0004, "cs1 only");
        do_write(1, 32'h4C48_0000, "restore1b");
        chk_acc(1, 32'h0200_0005, "wrap");
        chk_acc(1, 32'h01FF_FFFF, "no wrap");
        chk_acc(0, 32'h0400_0000, "wrap edge");

        for (int n = 0; n < 300; n++) begin
            logic [7:0] s, e;
            logic [31:0] d;
            s = 8'(8'h38 + $urandom % 8'h38);
            e = ($urandom % 3 == 0) ? 8'(s + (8'd1 << ($urandom % 4))) : 8'(8'h38 + $urandom % 8'h38);
            d = {e, s, ($urandom % 4 == 0) ? 16'($urandom) : 16'h0};
            do_write(int'($urandom % 4), d, "rand R4 R5 R6 R7 R8");
            for (int k = 0; k < 4; k++) begin
                chk_dec({1'b0, 8'(8'h38 + $urandom % 8'h38), 23'($urandom)}, "rand");
                chk_acc(int'($urandom % 3), {4'd0, 28'($urandom)}, "rand");
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule